// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Controller

This block decides the cycle in which a half-duplex Ethernet transmitter may begin, or begin again, to put a frame on the wire. While a frame is pending it watches carrier sense. It waits for the medium to stay quiet for a full interframe gap, and it can give up on a frame that has deferred too long. When a collision ends an attempt, it draws a random binary exponential backoff delay. The delay can be skipped for every collision, or only for collisions that happen while back pressure is being applied. After too many failed attempts it abandons the frame.

The transmitter raises `tx_req` and holds it high until it sees `tx_go`, `tx_abort` or `tx_excess_col`. After `tx_go` it keeps `tx_req` high for as long as the frame is on the wire. It lowers `tx_req` to mark the end of a frame or to acknowledge an abandonment. All timing is counted in `bit_tick` pulses, where one pulse is one bit time. In full-duplex mode, carrier sense and collision are ignored.

Top module: `hdx_defer_ctrl`

## Requirements
- R1: After synchronous reset, `tx_go`, `tx_abort` and `tx_excess_col` are low, and they stay low while `tx_req` is low.
- R2: A request is accepted on the first clock edge that sees `tx_req` high while the block is idle. `tx_go` is a single-cycle pulse. The medium idle and `bit_tick` high on every cycle, `tx_go` is high in the cycle that follows the (1+IFG_BITS)-th edge from that first edge. A frame then counts as on the wire until `tx_req` falls or a collision is seen.
- R3: The interframe gap counts only consecutive idle bit ticks. Any cycle with `crs` high (half duplex) restarts the count, so `tx_go` comes IFG_BITS ticks after the last busy cycle.
- R4: With `cfg_wait_forever` low, a frame whose deferral reaches DEFER_LIMIT bit ticks gets a single-cycle `tx_abort` pulse. No `tx_go` follows until `tx_req` has been lowered. The abort wins over a gap that completes on the same tick.
- R5: With `cfg_wait_forever` high, a frame never aborts however long the medium stays busy.
- R6: At the n-th collision of a frame, the backoff lasts r×SLOT_BITS bit ticks. Here r is the current 16-bit random register ANDed with 2^min(n,BACKOFF_CAP)−1. The random register loads 0xACE1 at reset and shifts left each clock, taking in bit15^bit13^bit12^bit10 at bit 0. After the backoff, a fresh interframe gap is counted.
- R7: With `cfg_no_backoff` high, every collision returns the frame straight to deferral, with no backoff delay.
- R8: With `cfg_bp_no_backoff` high, a collision that happens while `bp_active` is high skips the backoff. A collision while `bp_active` is low still backs off as in R6.
- R9: The MAX_ATTEMPTS-th collision of a frame gives a single-cycle `tx_excess_col` pulse instead of a retry. No further `tx_go` follows until `tx_req` has been lowered.
- R10: With `cfg_full_duplex` high, `crs` and `col` have no effect: the gap runs as if the medium were idle, and a collision neither retries nor abandons the frame.
- R11: Accepting a new request clears both the deferral time and the collision count from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_full_duplex | input | 1 | Full-duplex mode; carrier and collision ignored |
| cfg_wait_forever | input | 1 | 1: defer without limit; 0: abort at DEFER_LIMIT |
| cfg_no_backoff | input | 1 | Skip backoff after every collision |
| cfg_bp_no_backoff | input | 1 | Skip backoff after collisions during back pressure |
| tx_req | input | 1 | Frame pending / frame on the wire |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision indication |
| bp_active | input | 1 | Back pressure currently being applied |
| bit_tick | input | 1 | One pulse per bit time |
| tx_go | output | 1 | Pulse: start transmitting now |
| tx_abort | output | 1 | Pulse: frame dropped after excessive deferral |
| tx_excess_col | output | 1 | Pulse: frame dropped after too many collisions |

## Verification
All three outputs are registered. Each one reflects the decision taken at the clock edge that follows the stimulus, so the bench drives inputs on falling edges and compares outputs on the next falling edge against a behavioural model that steps on the rising edge. The directed checks count falling edges from the stimulus: 1+IFG_BITS for a fresh request, IFG_BITS after the last busy cycle or after a skipped backoff, 1+r×SLOT_BITS+IFG_BITS after a backed-off collision, 1+DEFER_LIMIT for an abort, and the very next edge for the excess-collision pulse. The random value r is predicted from the bench's own model of the random register, sampled on the edge where the collision is driven.

// File: rtl/hdx_defer_pkg.sv
package hdx_defer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_XMIT,
        ST_BACKOFF,
        ST_HOLD
    } tx_state_e;

    // Medium view after duplex masking
    typedef struct packed {
        logic busy;
        logic collide;
        logic skip_bo;
    } line_view_t;

    // Registered output events
    typedef struct packed {
        logic go;
        logic abort;
        logic excess;
    } tx_event_t;

    localparam int          RAND_W    = 16;
    localparam logic [15:0] RAND_SEED = 16'hACE1;

    // Taps at 16,14,13,11 (bits 15,13,12,10) - R6
    function automatic logic [15:0] rand_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // 2^min(n,cap)-1 as a 16-bit mask
    function automatic logic [15:0] range_mask(input int n, input int cap);
        int k;
        k = (n < cap) ? n : cap;
        if (k > 16) k = 16;
        return 16'((33'd1 << k) - 33'd1);
    endfunction

endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr
    import hdx_defer_pkg::*;
#(
    parameter logic [15:0] SEED = RAND_SEED
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] value
);

    // Free-running, advances on every clock - R6
    always_ff @(posedge clk) begin
        if (rst) value <= SEED;
        else     value <= rand_step(value);
    end

endmodule

// File: rtl/hdx_defer_timer.sv
module hdx_defer_timer #(
    parameter int LIMIT = 24288,
    parameter int GAP   = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic tick,
    input  logic busy,
    input  logic wait_forever,
    output logic limit_hit,
    output logic gap_done
);

    localparam int DW = $clog2(LIMIT + 1);
    localparam int GW = $clog2(GAP + 1);
    localparam logic [DW-1:0] D_LAST = DW'(LIMIT - 1);
    localparam logic [DW-1:0] D_MAX  = DW'(LIMIT);
    localparam logic [GW-1:0] G_LAST = GW'(GAP - 1);
    localparam logic [GW-1:0] G_MAX  = GW'(GAP);

    logic [DW-1:0] defer_cnt;
    logic [GW-1:0] gap_cnt;

    // Total deferral of the current frame; cleared on accept - R11
    always_ff @(posedge clk) begin
        if (rst || start)
            defer_cnt <= '0;
        else if (active && tick && defer_cnt != D_MAX)
            defer_cnt <= defer_cnt + 1'b1;
    end

    // Consecutive idle bit times; any busy cycle restarts - R3
    always_ff @(posedge clk) begin
        if (rst || !active || busy)
            gap_cnt <= '0;
        else if (tick && gap_cnt != G_MAX)
            gap_cnt <= gap_cnt + 1'b1;
    end

    assign limit_hit = active && tick && !wait_forever && (defer_cnt >= D_LAST);
    assign gap_done  = active && tick && !busy && (gap_cnt >= G_LAST);

endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff
    import hdx_defer_pkg::*;
#(
    parameter int SLOT     = 512,
    parameter int ATTEMPTS = 16,
    parameter int CAP      = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        collide,
    input  logic        skip,
    input  logic        active,
    input  logic        tick,
    input  logic [15:0] rnd,
    output logic        excess,
    output logic        done
);

    localparam int AW = $clog2(ATTEMPTS + 1);
    localparam int CW = $clog2(((2 ** CAP) - 1) * SLOT + 1);
    localparam logic [AW-1:0] A_LAST = AW'(ATTEMPTS - 1);

    logic [AW-1:0] attempts;
    logic [AW-1:0] attempts_nx;
    logic [15:0]   draw;
    logic [CW-1:0] wait_cnt;

    assign attempts_nx = attempts + 1'b1;
    assign draw        = rnd & range_mask(int'(attempts_nx), CAP);

    // Collision count of the current frame - R9, R11
    always_ff @(posedge clk) begin
        if (rst || start)
            attempts <= '0;
        else if (collide)
            attempts <= attempts_nx;
    end

    // Backoff length r*SLOT, counted down on bit ticks - R6
    always_ff @(posedge clk) begin
        if (rst)
            wait_cnt <= '0;
        else if (collide && !skip)
            wait_cnt <= CW'(draw * SLOT);
        else if (active && tick && wait_cnt != '0)
            wait_cnt <= wait_cnt - 1'b1;
    end

    assign excess = collide && (attempts == A_LAST);
    assign done   = active && (wait_cnt == '0);

endmodule

// File: rtl/hdx_defer_ctrl.sv
module hdx_defer_ctrl
    import hdx_defer_pkg::*;
#(
    parameter int DEFER_LIMIT  = 24288,
    parameter int IFG_BITS     = 96,
    parameter int SLOT_BITS    = 512,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_full_duplex,
    input  logic cfg_wait_forever,
    input  logic cfg_no_backoff,
    input  logic cfg_bp_no_backoff,
    input  logic tx_req,
    input  logic crs,
    input  logic col,
    input  logic bp_active,
    input  logic bit_tick,
    output logic tx_go,
    output logic tx_abort,
    output logic tx_excess_col
);

    tx_state_e   state, nxt;
    line_view_t  lv;
    tx_event_t   ev_nx, ev_q;
    logic [15:0] rnd;
    logic        start, collide_x;
    logic        limit_hit, gap_done;
    logic        excess, bo_done;

    // Duplex masking - R10; back-off skip selection - R7, R8
    assign lv.busy    = crs & ~cfg_full_duplex;
    assign lv.collide = col & ~cfg_full_duplex;
    assign lv.skip_bo = cfg_no_backoff | (cfg_bp_no_backoff & bp_active);

    assign start     = (state == ST_IDLE) && tx_req;
    assign collide_x = (state == ST_XMIT) && lv.collide;

    hdx_lfsr #(.SEED(RAND_SEED)) u_rand (
        .clk   (clk),
        .rst   (rst),
        .value (rnd)
    );

    hdx_defer_timer #(.LIMIT(DEFER_LIMIT), .GAP(IFG_BITS)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .active       (state == ST_DEFER),
        .tick         (bit_tick),
        .busy         (lv.busy),
        .wait_forever (cfg_wait_forever),
        .limit_hit    (limit_hit),
        .gap_done     (gap_done)
    );

    hdx_backoff #(.SLOT(SLOT_BITS), .ATTEMPTS(MAX_ATTEMPTS), .CAP(BACKOFF_CAP)) u_backoff (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .collide (collide_x),
        .skip    (lv.skip_bo),
        .active  (state == ST_BACKOFF),
        .tick    (bit_tick),
        .rnd     (rnd),
        .excess  (excess),
        .done    (bo_done)
    );

    always_comb begin
        nxt   = state;
        ev_nx = '0;
        unique case (state)
            ST_IDLE: begin
                if (tx_req) nxt = ST_DEFER;                 // R2
            end
            ST_DEFER: begin
                if (limit_hit) begin                        // R4 abort wins
                    nxt          = ST_HOLD;
                    ev_nx.abort  = 1'b1;
                end else if (gap_done) begin                // R2, R3
                    nxt          = ST_XMIT;
                    ev_nx.go     = 1'b1;
                end
            end
            ST_XMIT: begin
                if (lv.collide) begin
                    if (excess) begin                       // R9
                        nxt          = ST_HOLD;
                        ev_nx.excess = 1'b1;
                    end else if (lv.skip_bo) begin          // R7, R8
                        nxt = ST_DEFER;
                    end else begin                          // R6
                        nxt = ST_BACKOFF;
                    end
                end else if (!tx_req) begin
                    nxt = ST_IDLE;
                end
            end
            ST_BACKOFF: begin
                if (bo_done) nxt = ST_DEFER;
            end
            ST_HOLD: begin
                if (!tx_req) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ev_q  <= '0;                                    // R1
        end else begin
            state <= nxt;
            ev_q  <= ev_nx;
        end
    end

    assign tx_go         = ev_q.go;
    assign tx_abort      = ev_q.abort;
    assign tx_excess_col = ev_q.excess;

endmodule

// File: rtl/hdx_defer_checker.sv
module hdx_defer_checker (
    input logic clk,
    input logic rst,
    input logic fdx,
    input logic wait_forever,
    input logic crs,
    input logic col,
    input logic go,
    input logic abort,
    input logic excess
);

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({go, abort, excess}));                                   // R2

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);                                                      // R2

    AST_GO_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        go |-> (!$past(crs) || $past(fdx)));                              // R3

    AST_ABORT_ONLY_LIMITED: assert property (@(posedge clk) disable iff (rst)
        abort |-> !$past(wait_forever));                                  // R4

    AST_EXCESS_NEEDS_COL: assert property (@(posedge clk) disable iff (rst)
        excess |-> ($past(col) && !$past(fdx)));                          // R9

endmodule

bind hdx_defer_ctrl hdx_defer_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .fdx          (cfg_full_duplex),
    .wait_forever (cfg_wait_forever),
    .crs          (crs),
    .col          (col),
    .go           (tx_go),
    .abort        (tx_abort),
    .excess       (tx_excess_col)
);

// File: tb/sim_hdx_defer_ctrl.sv
`timescale 1ns/1ps
module sim_hdx_defer_ctrl;

    localparam int LIM  = 200;
    localparam int IFG  = 12;
    localparam int SLOT = 4;
    localparam int ATT  = 16;
    localparam int CAP  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fdx = 0, wf = 1, nbo = 0, bpn = 0;
    logic req = 0, crs = 0, col = 0, bp = 0, tick = 1;
    logic go, ab, ex;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hdx_defer_ctrl #(
        .DEFER_LIMIT(LIM), .IFG_BITS(IFG), .SLOT_BITS(SLOT),
        .MAX_ATTEMPTS(ATT), .BACKOFF_CAP(CAP)
    ) u0 (
        .clk(clk), .rst(rst),
        .cfg_full_duplex(fdx), .cfg_wait_forever(wf),
        .cfg_no_backoff(nbo), .cfg_bp_no_backoff(bpn),
        .tx_req(req), .crs(crs), .col(col), .bp_active(bp), .bit_tick(tick),
        .tx_go(go), .tx_abort(ab), .tx_excess_col(ex)
    );

    // ---------------- behavioural reference model ----------------
    // states: 0 idle, 1 waiting for medium, 2 on wire, 3 backing off, 4 dropped
    int m_st, m_def, m_ifg, m_att, m_bo, m_lfsr;
    bit m_go, m_ab, m_ex;

    function automatic int bmask(input int n);
        int k;
        k = (n < CAP) ? n : CAP;
        return (1 << k) - 1;
    endfunction

    always @(posedge clk) begin
        bit busy, cl, skip, g, a, e;
        if (rst) begin
            m_st = 0; m_def = 0; m_ifg = 0; m_att = 0; m_bo = 0;
            m_lfsr = 16'hACE1; m_go = 0; m_ab = 0; m_ex = 0;
        end else begin
            busy = crs && !fdx;
            cl   = col && !fdx;
            skip = nbo || (bpn && bp);
            g = 0; a = 0; e = 0;
            case (m_st)
                0: if (req) begin m_st = 1; m_def = 0; m_att = 0; m_ifg = 0; end
                1: begin
                    if (tick && m_def < LIM) m_def++;
                    if (tick && !wf && m_def >= LIM) begin m_st = 4; a = 1; end
                    else if (busy) m_ifg = 0;
                    else if (tick) begin
                        m_ifg++;
                        if (m_ifg >= IFG) begin m_st = 2; g = 1; end
                    end
                end
                2: begin
                    if (cl) begin
                        m_att++;
                        if (m_att == ATT) begin m_st = 4; e = 1; end
                        else if (skip) begin m_st = 1; m_ifg = 0; end
                        else begin m_st = 3; m_bo = (m_lfsr & bmask(m_att)) * SLOT; end
                    end else if (!req) m_st = 0;
                end
                3: begin
                    if (m_bo == 0) begin m_st = 1; m_ifg = 0; end
                    else if (tick) m_bo--;
                end
                default: if (!req) m_st = 0;
            endcase
            m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^
                      (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1)) & 16'hFFFF;
            m_go = g; m_ab = a; m_ex = e;
        end
    end

    // Per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            checks += 3;
            if (go !== m_go) begin
                errors++;
                $display("FAIL R2 tx_go actual=%0b expected=%0b at %0t", go, m_go, $time);
            end
            if (ab !== m_ab) begin
                errors++;
                $display("FAIL R4 tx_abort actual=%0b expected=%0b at %0t", ab, m_ab, $time);
            end
            if (ex !== m_ex) begin
                errors++;
                $display("FAIL R9 tx_excess_col actual=%0b expected=%0b at %0t", ex, m_ex, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // which: 0 go, 1 abort, 2 excess; c = falling edges until seen, -1 if never
    task automatic wait_evt(input int which, input int maxc, output int c);
        c = -1;
        for (int i = 1; i <= maxc && c < 0; i++) begin
            @(negedge clk);
            if ((which == 0 && go) || (which == 1 && ab) || (which == 2 && ex)) c = i;
        end
    endtask

    task automatic col_pulse();
        col = 1'b1;
        @(negedge clk);
        col = 1'b0;
    endtask

    task automatic end_frame();
        req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int c, r, cyc;
        bit in_x, fin, seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset with no request
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!go && !ab && !ex, "R1 outputs after reset", int'({go, ab, ex}), 0);
        end

        // R2: idle medium, fresh request
        req = 1;
        wait_evt(0, IFG + 20, c);
        check(c == IFG + 1, "R2 go delay", c, IFG + 1);
        @(negedge clk);
        check(!go, "R2 go is one cycle", int'(go), 0);
        end_frame();

        // R3: carrier busy for 7 cycles, then gap
        req = 1; crs = 1;
        repeat (7) @(negedge clk);
        crs = 0;
        wait_evt(0, IFG + 20, c);
        check(c == IFG, "R3 gap after carrier", c, IFG);
        end_frame();

        // R3: short carrier blip inside the gap restarts it
        req = 1;
        repeat (5) @(negedge clk);
        crs = 1;
        @(negedge clk);
        crs = 0;
        wait_evt(0, IFG + 20, c);
        check(c == IFG, "R3 gap restarted by blip", c, IFG);
        end_frame();

        // R10: full duplex ignores carrier and collision
        fdx = 1; crs = 1; req = 1;
        wait_evt(0, IFG + 20, c);
        check(c == IFG + 1, "R10 go despite carrier", c, IFG + 1);
        col = 1; seen = 0;
        for (int i = 0; i < 3 * IFG; i++) begin
            @(negedge clk);
            if (go || ex) seen = 1;
        end
        col = 0;
        check(!seen, "R10 collision ignored", int'(seen), 0);
        end_frame();
        fdx = 0; crs = 0;

        // R4: limited deferral aborts
        wf = 0; crs = 1; req = 1;
        wait_evt(1, LIM + 20, c);
        check(c == LIM + 1, "R4 abort delay", c, LIM + 1);
        crs = 0; seen = 0;
        for (int i = 0; i < IFG + 5; i++) begin
            @(negedge clk);
            if (go) seen = 1;
        end
        check(!seen, "R4 no go after abort", int'(seen), 0);
        end_frame();

        // R11: deferral time restarts with each accepted request
        req = 1; crs = 1;
        repeat (LIM - 20) @(negedge clk);
        crs = 0;
        wait_evt(0, IFG + 20, c);
        check(c == IFG, "R11 first frame sent", c, IFG);
        end_frame();
        req = 1; crs = 1;
        wait_evt(1, LIM + 20, c);
        check(c == LIM + 1, "R11 full limit for new frame", c, LIM + 1);
        end_frame();
        crs = 0;

        // R5: unlimited deferral
        wf = 1; crs = 1; req = 1; seen = 0;
        for (int i = 0; i < 2 * LIM; i++) begin
            @(negedge clk);
            if (ab) seen = 1;
        end
        check(!seen, "R5 no abort", int'(seen), 0);
        crs = 0;
        wait_evt(0, IFG + 20, c);
        check(c == IFG, "R5 go after long defer", c, IFG);

        // R7: no backoff at all (collision 1)
        nbo = 1;
        col_pulse();
        wait_evt(0, IFG + 20, c);
        check(c == IFG, "R7 immediate retry", c, IFG);
        nbo = 0;

        // R8: back pressure active skips backoff (collision 2)
        bpn = 1; bp = 1;
        col_pulse();
        wait_evt(0, IFG + 20, c);
        check(c == IFG, "R8 retry under back pressure", c, IFG);

        // R8: back pressure idle still backs off (collision 3)
        bp = 0;
        r = m_lfsr & bmask(3);
        col_pulse();
        wait_evt(0, 5000, c);
        check(c == 1 + r * SLOT + IFG, "R8 backoff without back pressure", c, 1 + r * SLOT + IFG);
        bpn = 0;

        // R6: backoff range grows with attempt count (collision 4)
        r = m_lfsr & bmask(4);
        col_pulse();
        wait_evt(0, 5000, c);
        check(c == 1 + r * SLOT + IFG, "R6 backoff length", c, 1 + r * SLOT + IFG);
        end_frame();

        // R9 / R11: attempt count restarts, then 16th collision abandons
        nbo = 1; req = 1;
        wait_evt(0, IFG + 20, c);
        check(c == IFG + 1, "R11 new frame go", c, IFG + 1);
        for (int i = 1; i < ATT; i++) begin
            col_pulse();
            wait_evt(0, IFG + 20, c);
            check(c == IFG, "R9 retry before limit", c, IFG);
        end
        col_pulse();
        check(ex == 1'b1, "R9 excess pulse", int'(ex), 1);
        seen = 0;
        for (int i = 0; i < IFG + 5; i++) begin
            @(negedge clk);
            if (go) seen = 1;
        end
        check(!seen, "R9 no go after excess", int'(seen), 0);
        end_frame();
        nbo = 0;

        // Random traffic, compared against the model every cycle (R2-R10)
        cyc = 0;
        while (cyc < 40000) begin
            fdx = ($urandom % 5 == 0); wf = $urandom % 2;
            nbo = ($urandom % 4 == 0); bpn = $urandom % 2;
            tick = 1; crs = 0; col = 0; bp = 0;
            req = 1; in_x = 0; fin = 0;
            while (!fin && cyc < 40000) begin
                @(negedge clk);
                cyc++;
                if (ab || ex) begin
                    req = 0; col = 0; fin = 1;
                end else begin
                    if (go) in_x = 1;
                    crs  = ($urandom % 6 == 0);
                    bp   = $urandom % 2;
                    tick = ($urandom % 4 != 0);
                    col  = 0;
                    if (in_x) begin
                        if ($urandom % 4 == 0) begin
                            col = 1;
                            if (!fdx) in_x = 0;
                        end else if ($urandom % 3 == 0) begin
                            req = 0; fin = 1;
                        end
                    end
                end
            end
            col = 0; crs = 0; tick = 1; req = 0;
            repeat (3) @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule